// File: doc/BRIEF.md
# Sampled-Phase Second-Order Tracking Loop

This block is a discrete-time phase-locked loop that works directly on phase samples. Each accepted sample carries a 32-bit phase word and a 5-bit gain exponent. From these the loop updates three registers: the previous input phase, the filtered frequency and the filtered output phase. It returns the new output phase together with the phase increment applied on that update, which is the instantaneous frequency.

Every sum and difference is two's-complement and wraps modulo 2^32. This lets phase and frequency live naturally in the first Nyquist zone. The loop gain is set only by arithmetic right shifts, so the datapath has no multipliers.

Phase unwrapping and slip handling belong to the surrounding logic and are not part of this block.

Top module: `pll_phase_track`

## Requirements
- R1: After reset, `out_valid`, `out_phase` and `out_freq` are zero and all loop state is zero. From that state, one update with phase 0x00010000 and shift 10 returns phase 0x000000C2 and frequency 0x000000C2.
- R2: Let s be the effective shift, x the input phase, and xp, fp, yp the stored input phase, frequency and output phase. With e = x - fp, the new stored frequency is fn = fp + ((2^(s-1) + e - xp) >>> s), where >>> is an arithmetic right shift.
- R3: The returned frequency is fo = fn + ((2^s + e - yp) >>> (s-1)). The returned phase is yn = yp + fo, and yn becomes the stored output phase.
- R4: The stored frequency is fn and not fo. After the R1 update, a second update with phase 0x00010000 and shift 10 returns frequency 0x000000C1 and phase 0x00000183.
- R5: All arithmetic wraps modulo 2^32 with no saturation, including for inputs near +2^31 and -2^31.
- R6: An in_shift value of 0 acts as 1, and a value of 31 acts as 30. Values from 1 to 30 are used as given.
- R7: The result appears on `out_phase`/`out_freq` with `out_valid` high on the clock edge after the one that samples `in_valid` high. While `in_valid` is low, `out_valid` is low and the outputs hold.
- R8: Cycles with `in_valid` low leave the loop state unchanged, whatever values `in_phase` and `in_shift` carry.
- R9: The shift may differ from one update to the next. Each update uses only its own shift with the current state, and updates may arrive on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe; an update is taken on each cycle it is high |
| in_phase | input | 32 | Input phase sample, signed, wraps modulo 2^32 |
| in_shift | input | 5 | Loop gain exponent (frequency gain 2^-shift) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_phase | output | 32 | New output phase |
| out_freq | output | 32 | Instantaneous frequency (phase increment of this update) |

## Verification
Each update's phase and frequency are due exactly one clock edge after the edge that samples `in_valid`. The bench drives inputs on the falling edge and reads results on the following falling edge. In back-to-back bursts it checks update k while it drives update k+1. Idle stretches are checked on every falling edge: the outputs must be unchanged. The next update after an idle stretch must then match a state that saw no change, which shows that the idle inputs had no effect.

// File: rtl/pll_pkg.sv
package pll_pkg;
  typedef enum logic {
    OUT_ONE = 1'b0,
    OUT_TWO = 1'b1
  } out_stage_e;

  localparam int SHIFT_MIN = 1;
endpackage

// File: rtl/pll_shift_clamp.sv
module pll_shift_clamp #(
  parameter int SW = 5,
  parameter int LO = 1,
  parameter int HI = 30
) (
  input  logic [SW-1:0] raw_i,
  output logic [SW-1:0] eff_o
);
  localparam logic [SW-1:0] LO_V = SW'(LO);
  localparam logic [SW-1:0] HI_V = SW'(HI);

  always_comb begin
    if (raw_i < LO_V)      eff_o = LO_V;
    else if (raw_i > HI_V) eff_o = HI_V;
    else                   eff_o = raw_i;
  end
endmodule

// File: rtl/pll_round_shr.sv
module pll_round_shr #(
  parameter int PW      = 32,
  parameter int SW      = 5,
  parameter bit BIAS_UP = 1'b0
) (
  input  logic signed [PW-1:0] diff_i,
  input  logic        [SW-1:0] amt_i,
  output logic signed [PW-1:0] res_o
);
  localparam logic signed [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

  logic        [SW-1:0] bexp;
  logic signed [PW-1:0] bias;
  logic signed [PW-1:0] sum;

  // bias exponent sits one above or one below the shift amount
  if (BIAS_UP) begin : g_up
    assign bexp = amt_i + SW'(1);
  end else begin : g_dn
    assign bexp = amt_i - SW'(1);
  end

  always_comb begin
    bias  = ONE << bexp;
    sum   = bias + diff_i;
    res_o = sum >>> amt_i;
  end
endmodule

// File: rtl/pll_loop_core.sv
module pll_loop_core #(
  parameter int PW = 32,
  parameter int SW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_i,
  input  logic signed [PW-1:0] x_i,
  input  logic        [SW-1:0] sh_i,
  output logic signed [PW-1:0] y_new_o,
  output logic signed [PW-1:0] f_out_o,
  output logic signed [PW-1:0] y_state_o
);
  logic signed [PW-1:0] x_q, f_q, y_q;
  logic signed [PW-1:0] x_d, f_d, y_d;
  logic signed [PW-1:0] err, dif_f, dif_p, step_f, step_p, f_new;
  logic        [SW-1:0] sh_p;

  always_comb begin
    err   = x_i - f_q;
    dif_f = err - x_q;
    dif_p = err - y_q;
    sh_p  = sh_i - SW'(1);
  end

  pll_round_shr #(.PW(PW), .SW(SW), .BIAS_UP(1'b0)) u_shr_freq (
    .diff_i(dif_f),
    .amt_i (sh_i),
    .res_o (step_f)
  );

  pll_round_shr #(.PW(PW), .SW(SW), .BIAS_UP(1'b1)) u_shr_phase (
    .diff_i(dif_p),
    .amt_i (sh_p),
    .res_o (step_p)
  );

  always_comb begin
    f_new   = f_q + step_f;
    f_out_o = f_new + step_p;
    y_new_o = y_q + f_out_o;
  end

  always_comb begin
    x_d = x_q;
    f_d = f_q;
    y_d = y_q;
    if (upd_i) begin
      x_d = x_i;
      f_d = f_new;
      y_d = y_new_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      f_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= x_d;
      f_q <= f_d;
      y_q <= y_d;
    end
  end

  assign y_state_o = y_q;
endmodule

// File: rtl/pll_phase_track.sv
module pll_phase_track #(
  parameter int                 PW       = 32,
  parameter pll_pkg::out_stage_e OUT_MODE = pll_pkg::OUT_ONE,
  localparam int                SW       = $clog2(PW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [PW-1:0] in_phase,
  input  logic [SW-1:0] in_shift,
  output logic          out_valid,
  output logic [PW-1:0] out_phase,
  output logic [PW-1:0] out_freq
);
  localparam int SHIFT_HI = PW - 2;

  logic [1:0]           rsync_q;
  logic                 core_rst_n;
  logic [SW-1:0]        shift_eff;
  logic signed [PW-1:0] y_new, f_out, y_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  pll_shift_clamp #(.SW(SW), .LO(pll_pkg::SHIFT_MIN), .HI(SHIFT_HI)) u_clamp (
    .raw_i(in_shift),
    .eff_o(shift_eff)
  );

  pll_loop_core #(.PW(PW), .SW(SW)) u_core (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .upd_i    (in_valid),
    .x_i      ($signed(in_phase)),
    .sh_i     (shift_eff),
    .y_new_o  (y_new),
    .f_out_o  (f_out),
    .y_state_o(y_state)
  );

  if (OUT_MODE == pll_pkg::OUT_ONE) begin : g_out1
    logic          v_q, v_d;
    logic [PW-1:0] p_q, p_d, f_q, f_d;

    always_comb begin
      v_d = in_valid;
      p_d = p_q;
      f_d = f_q;
      if (in_valid) begin
        p_d = y_new;
        f_d = f_out;
      end
    end

    always_ff @(posedge clk or negedge core_rst_n) begin
      if (!core_rst_n) begin
        v_q <= 1'b0;
        p_q <= '0;
        f_q <= '0;
      end else begin
        v_q <= v_d;
        p_q <= p_d;
        f_q <= f_d;
      end
    end

    assign out_valid = v_q;
    assign out_phase = p_q;
    assign out_freq  = f_q;
  end else begin : g_out2
    logic          va_q, va_d, vb_q, vb_d;
    logic [PW-1:0] pa_q, pa_d, fa_q, fa_d, pb_q, pb_d, fb_q, fb_d;

    always_comb begin
      va_d = in_valid;
      vb_d = va_q;
      pa_d = pa_q;
      fa_d = fa_q;
      pb_d = pb_q;
      fb_d = fb_q;
      if (in_valid) begin
        pa_d = y_new;
        fa_d = f_out;
      end
      if (va_q) begin
        pb_d = pa_q;
        fb_d = fa_q;
      end
    end

    always_ff @(posedge clk or negedge core_rst_n) begin
      if (!core_rst_n) begin
        va_q <= 1'b0;
        vb_q <= 1'b0;
        pa_q <= '0;
        fa_q <= '0;
        pb_q <= '0;
        fb_q <= '0;
      end else begin
        va_q <= va_d;
        vb_q <= vb_d;
        pa_q <= pa_d;
        fa_q <= fa_d;
        pb_q <= pb_d;
        fb_q <= fb_d;
      end
    end

    assign out_valid = vb_q;
    assign out_phase = pb_q;
    assign out_freq  = fb_q;
  end
endmodule

// File: rtl/pll_phase_track_chk.sv
module pll_phase_track_chk #(
  parameter int PW        = 32,
  parameter int SW        = 5,
  parameter bit ONE_STAGE = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [PW-1:0] out_phase,
  input logic [PW-1:0] out_freq,
  input logic [PW-1:0] y_state,
  input logic [SW-1:0] shift_eff
);
  // R6: effective shift always inside the legal range
  always @(posedge clk) begin
    if (rst_n) begin
      p_shift_range_r6: assert (shift_eff >= SW'(1) && shift_eff <= SW'(PW - 2))
        else $error("shift_eff out of range");
    end
  end

  // R8: state untouched on idle cycles
  p_state_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(y_state));

  if (ONE_STAGE) begin : g_one
    // R7: result strobe one cycle after an accepted sample
    p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

    // R7: idle cycle gives no strobe and held outputs
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_phase) && $stable(out_freq)));

    // R3: stored phase advances by the reported frequency
    p_phase_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (y_state == $past(y_state) + out_freq));
  end
endmodule

bind pll_phase_track pll_phase_track_chk #(
  .PW(PW),
  .SW(SW),
  .ONE_STAGE(OUT_MODE == pll_pkg::OUT_ONE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_phase(out_phase),
  .out_freq (out_freq),
  .y_state  (y_state),
  .shift_eff(shift_eff)
);

// File: tb/tb_pll_phase_track.sv
module tb_pll_phase_track;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_phase;
  logic [4:0]  in_shift;
  logic        out_valid;
  logic [31:0] out_phase;
  logic [31:0] out_freq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic signed [31:0] m_x, m_f, m_y;

  always #4 clk = ~clk;

  pll_phase_track dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_phase (in_phase),
    .in_shift (in_shift),
    .out_valid(out_valid),
    .out_phase(out_phase),
    .out_freq (out_freq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic [31:0] xi, input logic [4:0] si,
                            output logic [31:0] yo, output logic [31:0] fo);
    int s;
    logic signed [31:0] e, t, fn, u, fout;
    s    = (si < 5'd1) ? 1 : (si > 5'd30) ? 30 : int'(si);
    e    = $signed(xi) - m_f;
    t    = (32'sd1 <<< (s - 1)) + e - m_x;
    fn   = m_f + (t >>> s);
    u    = (32'sd1 <<< s) + e - m_y;
    fout = fn + (u >>> (s - 1));
    m_x  = $signed(xi);
    m_f  = fn;
    m_y  = m_y + fout;
    yo   = m_y;
    fo   = fout;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_phase = '0;
    in_shift = 5'd10;
    m_x = '0; m_f = '0; m_y = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one isolated update, result checked one edge later
  task automatic one_update(input string tag, input logic [31:0] x, input logic [4:0] s);
    logic [31:0] ey, ef;
    @(negedge clk);
    in_valid = 1'b1;
    in_phase = x;
    in_shift = s;
    model_step(x, s, ey, ef);
    @(negedge clk);
    in_valid = 1'b0;
    in_phase = $urandom;
    in_shift = 5'($urandom);
    chk({tag, " valid"}, {31'b0, out_valid}, 32'd1);
    chk({tag, " phase"}, out_phase, ey);
    chk({tag, " freq"}, out_freq, ef);
  endtask

  // back-to-back updates: check k while driving k+1
  task automatic burst(input string tag, input int n, input bit wide);
    logic [31:0] ey, ef, x;
    logic [4:0]  s;
    bit have;
    have = 1'b0;
    ey = '0; ef = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (have) begin
        chk({tag, " valid"}, {31'b0, out_valid}, 32'd1);
        chk({tag, " phase"}, out_phase, ey);
        chk({tag, " freq"}, out_freq, ef);
      end
      x = wide ? ((i % 2 == 0) ? 32'h7FFF_FF00 + $urandom % 512 : 32'h8000_0000 + $urandom % 512)
               : $urandom;
      s = 5'($urandom);
      in_valid = 1'b1;
      in_phase = x;
      in_shift = s;
      model_step(x, s, ey, ef);
      have = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, {31'b0, out_valid}, 32'd1);
    chk({tag, " phase"}, out_phase, ey);
    chk({tag, " freq"}, out_freq, ef);
  endtask

  // idle stretch with noisy inputs: outputs hold, no strobe
  task automatic idle(input int n);
    logic [31:0] hp, hf;
    @(negedge clk);
    hp = out_phase;
    hf = out_freq;
    for (int i = 0; i < n; i++) begin
      in_phase = $urandom;
      in_shift = 5'($urandom);
      @(negedge clk);
      chk("R7 idle valid", {31'b0, out_valid}, 32'd0);
      chk("R7 idle phase hold", out_phase, hp);
      chk("R7 idle freq hold", out_freq, hf);
    end
  endtask

  initial begin
    in_valid = 1'b0;
    in_phase = '0;
    in_shift = 5'd10;
    rst_n    = 1'b0;
    do_reset();

    // R1: reset state
    chk("R1 reset valid", {31'b0, out_valid}, 32'd0);
    chk("R1 reset phase", out_phase, 32'd0);
    chk("R1 reset freq", out_freq, 32'd0);

    // R1 and R4: known two-step sequence from reset
    one_update("R1 first update", 32'h0001_0000, 5'd10);
    chk("R1 first phase const", out_phase, 32'h0000_00C2);
    chk("R1 first freq const", out_freq, 32'h0000_00C2);
    one_update("R4 second update", 32'h0001_0000, 5'd10);
    chk("R4 second freq const", out_freq, 32'h0000_00C1);
    chk("R4 second phase const", out_phase, 32'h0000_0183);

    // R2, R3, R9: every shift value, several input patterns
    for (int s = 0; s < 32; s++) begin
      one_update("R2 R3 ramp", 32'(s) * 32'h0123_4567, 5'(s));
      one_update("R2 R3 rand", $urandom, 5'(s));
      one_update("R9 step", 32'h4000_0000, 5'(s));
    end

    // R6: clamped extremes from a fresh state
    do_reset();
    one_update("R6 shift0", 32'h0001_0000, 5'd0);
    do_reset();
    one_update("R6 shift1 same", 32'h0001_0000, 5'd1);
    do_reset();
    one_update("R6 shift31", 32'h7654_3210, 5'd31);
    one_update("R6 shift30 follow", 32'h7654_3210, 5'd30);

    // R5: wrap near both ends of the range
    do_reset();
    one_update("R5 max pos", 32'h7FFF_FFFF, 5'd1);
    one_update("R5 min neg", 32'h8000_0000, 5'd1);
    one_update("R5 min neg shift30", 32'h8000_0001, 5'd30);
    burst("R5 wide burst", 200, 1'b1);

    // R8: noisy idle then update must follow untouched state
    idle(6);
    one_update("R8 after idle", $urandom, 5'd7);
    idle(3);

    // R9 and R7: long back-to-back random burst with varying shift
    burst("R9 burst", 1500, 1'b0);
    idle(2);
    for (int k = 0; k < 20; k++) begin
      burst("R7 short burst", 1 + k % 4, 1'b0);
      idle(1 + k % 3);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule